// File: doc/BRIEF.md
# Shared-Word Interrupt Aggregator

This block collects a configurable group of interrupt sources and presents them to a parent interrupt controller through one level-sensitive request line. Every source owns two bits in a single 32-bit register: an enable bit in the lower half and a latched pending bit that sits exactly 16 positions above it in the upper half. A rising edge on a source input latches its pending bit. Software clears a pending bit by writing 1 to it.

Writing 0 to a pending bit leaves it unchanged. Software can therefore rewrite the enables with zeros in the upper half and lose no event. The sources start at a configurable bit offset within each half, so several instances with different widths and positions can sit side by side. Each instance answers at its own register address on a simple single-cycle bus. A read returns the whole word at once and has no side effects.

The request line is registered. It is high whenever at least one source is both pending and enabled.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous active-low reset, every enable and pending bit is 0, a read returns 0x0000_0000, and `irq_out` is low.
- R2: A read at the register address returns enable i at bit SRC_BASE+i and pending i at bit 16+SRC_BASE+i. With the defaults (7 sources, base 0), enables are in bits [6:0] and pending bits are in [22:16]. Reading changes no state, so two reads in a row return the same word.
- R3: A write at the register address loads write-data bits [SRC_BASE+NUM_SRC-1:SRC_BASE] into the enables, whatever the upper half holds.
- R4: A write with 1 in pending bit position 16+SRC_BASE+i clears pending bit i. A 0 in that position leaves the bit unchanged.
- R5: A pending bit is set by a 0-to-1 transition of its source input, whether or not the source is enabled. A source held high does not set the bit again after it has been cleared.
- R6: When a source's rising edge and a write-1-to-clear of its pending bit occur in the same cycle, the pending bit ends up set.
- R7: `irq_out` is high exactly when, on the previous clock edge, the AND of pending and enable bits was non-zero. It follows a change in state one clock later.
- R8: `irq_out` stays high until every source that is both pending and enabled has been cleared or disabled.
- R9: Bit positions outside the configured sources always read 0, and writes to them have no effect.
- R10: An access with `bus_sel` high at any other address changes nothing and reads back 0.
- R11: Writing all ones to the upper half and then all zeros to the lower half leaves no bit pending, every source disabled, and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not selected) |
| src_in | input | NUM_SRC | Interrupt source inputs, rising-edge sensitive |
| irq_out | output | 1 | Level request to the parent controller |

## Verification
The hardest case to produce from the ports is a rising edge on a source in the same cycle as a write that clears that source's pending bit (R6). The pending bit must already be set and the source must have returned low beforehand. The bench first pulses the source to set the bit. It then drives the source high again and places the clearing write on the bus at the same falling edge, so both reach the same rising edge. A second hard case is a source held high through a clear (R5). The bench keeps the input asserted across the write and afterwards reads the word to confirm that no new pending bit appears.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the shared-word interrupt aggregator.
// Assumes a 32-bit register split into two 16-bit halves.
package irqc_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irqc_src_latch.sv
// Module: per-source edge detector and pending latch.
// Does: sets pending bit i on a rising edge of src_in[i]; clears it on clr_vec[i].
// Assumes: src_in is synchronous to clk; when set and clear coincide, set wins.
module irqc_src_latch #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] stat_q
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;

    // Purpose: keep the previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_in;
    end

    // Purpose: flag the 0-to-1 transitions seen this cycle.
    always_comb rise = src_in & ~src_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Purpose: hold pending bit i; a new edge overrides a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          stat_q[i] <= 1'b0;
            else if (rise[i])    stat_q[i] <= 1'b1;
            else if (clr_vec[i]) stat_q[i] <= 1'b0;
        end

        // R5 R6
        status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> stat_q[i]);
        // R4
        status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !rise[i]) |=> !stat_q[i]);
        // R4
        status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[i] && !rise[i]) |=> (stat_q[i] == $past(stat_q[i])));
    end
endmodule

// File: rtl/irqc_regfile.sv
// Module: register decode, enable storage and read-word assembly.
// Does: a write loads the enables and turns 1s in the pending half into clears.
// Assumes: single-cycle accesses; read data is combinational and has no side effects.
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int              NUM_SRC  = 7,
    parameter int              SRC_BASE = 0,
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h018
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  word_t              bus_wdata,
    output word_t              bus_rdata,
    input  logic [NUM_SRC-1:0] stat_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] clr_vec
);
    localparam int EN_LO = SRC_BASE;
    localparam int ST_LO = HALF_W + SRC_BASE;

    logic  hit;
    logic  wr_hit;
    word_t word;
    logic  unused_wdata;

    // Purpose: decode an access aimed at this register.
    always_comb begin
        hit    = bus_sel && (bus_addr == REG_ADDR);
        wr_hit = hit && bus_we;
    end

    // Purpose: store the enables written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_hit) en_q <= bus_wdata[EN_LO +: NUM_SRC];
    end

    // Purpose: turn 1s in the pending half of a write into per-source clears.
    always_comb clr_vec = wr_hit ? bus_wdata[ST_LO +: NUM_SRC] : '0;

    // Purpose: assemble the read word; unused positions stay 0.
    always_comb begin
        word                    = '0;
        word[EN_LO +: NUM_SRC]  = en_q;
        word[ST_LO +: NUM_SRC]  = stat_q;
        bus_rdata               = (hit && !bus_we) ? word : '0;
    end

    // Purpose: mark write-data bits that no source uses.
    assign unused_wdata = ^bus_wdata;

    // R3
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (en_q == $past(bus_wdata[EN_LO +: NUM_SRC])));
    // R10
    enable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(en_q));
endmodule

// File: rtl/irqc_irq_gen.sv
// Module: registered level request to the parent controller.
// Does: raises irq_q when any source is both pending and enabled.
// Assumes: the request follows state changes with a one-clock lag.
module irqc_irq_gen #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] stat_q,
    output logic               irq_q
);
    logic active;

    // Purpose: detect any source that is both enabled and pending.
    always_comb active = |(en_q & stat_q);

    // Purpose: register the level request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= active;
    end

    // R7 R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> irq_q);
    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !irq_q);
endmodule

// File: rtl/irq_combiner.sv
// Module: top of the shared-word interrupt aggregator.
// Does: wires source latching, register access and request generation together.
// Assumes: SRC_BASE + NUM_SRC <= 16; synchronous active-low reset.
module irq_combiner #(
    parameter int                NUM_SRC  = 7,
    parameter int                SRC_BASE = 0,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h018
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] clr_vec;

    irqc_src_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .clr_vec(clr_vec), .stat_q(stat_q)
    );

    irqc_regfile #(
        .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE),
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_q(stat_q), .en_q(en_q), .clr_vec(clr_vec)
    );

    irqc_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .stat_q(stat_q), .irq_q(irq_out)
    );
endmodule

// File: tb/test_irq_combiner.sv
// Bench: directed scenarios for irq_combiner with default parameters.
module test_irq_combiner;
    localparam int          CLK_PERIOD = 10;
    localparam int          NSRC       = 7;
    localparam logic [11:0] ADDR       = 12'h018;
    localparam logic [11:0] OTHER      = 12'h01C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src_in = '0;
    logic            irq_out;
    int              checks = 0;
    int              errors = 0;

    irq_combiner i_irq_combiner (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk) src_in[idx] = 1'b1;
        @(negedge clk) src_in[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(ADDR, d);
        check("R1 reset word", d, 32'h0);
        check("R1 reset irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_init_seq();
        logic [31:0] d;
        pulse(0); pulse(3);
        bus_write(ADDR, 32'hFFFF_0000);
        bus_write(ADDR, 32'h0000_0000);
        bus_read(ADDR, d);
        check("R11 init word", d, 32'h0);
        check("R11 init irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_latch_disabled();
        logic [31:0] d;
        logic [31:0] d2;
        pulse(2);
        bus_read(ADDR, d);
        bus_read(ADDR, d2);
        check("R5 disabled latch", d, 32'h0004_0000);
        check("R2 read no side effect", d2, d);
        check("R5 disabled no irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(ADDR, 32'h0000_0004);
        check("R7 irq lags one clock", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 irq asserted", {31'b0, irq_out}, 32'h1);
        bus_read(ADDR, d);
        check("R3 enable loaded, pending kept", d, 32'h0004_0004);
    endtask

    task automatic t_clear_partial();
        logic [31:0] d;
        pulse(5);
        bus_write(ADDR, 32'h0000_0024);
        bus_write(ADDR, 32'h0004_0024);
        bus_read(ADDR, d);
        check("R4 clear one bit only", d, 32'h0020_0024);
        check("R8 irq held by other source", {31'b0, irq_out}, 32'h1);
        bus_write(ADDR, 32'h0020_0024);
        bus_read(ADDR, d);
        check("R4 last bit cleared", d, 32'h0000_0024);
        check("R8 irq released", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_level_held();
        logic [31:0] d;
        @(negedge clk) src_in[1] = 1'b1;
        bus_read(ADDR, d);
        check("R5 edge sets bit", d, 32'h0002_0024);
        bus_write(ADDR, 32'h0002_0024);
        repeat (3) @(negedge clk);
        bus_read(ADDR, d);
        check("R5 held level no re-set", d, 32'h0000_0024);
        src_in[1] = 1'b0;
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(3);
        @(negedge clk);
        src_in[3] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR; bus_wdata = 32'h0008_0024;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0; src_in[3] = 1'b0;
        bus_read(ADDR, d);
        check("R6 set wins over clear", d, 32'h0008_0024);
        bus_write(ADDR, 32'h0008_0024);
        bus_read(ADDR, d);
        check("R4 cleared afterwards", d, 32'h0000_0024);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        bus_write(ADDR, 32'hFF80_FFA4);
        bus_read(ADDR, d);
        check("R9 outside bits ignored", d, 32'h0000_0024);
    endtask

    task automatic t_addr_miss();
        logic [31:0] d;
        pulse(6);
        bus_write(OTHER, 32'h0040_0000);
        bus_read(OTHER, d);
        check("R10 other address reads 0", d, 32'h0);
        bus_read(ADDR, d);
        check("R10 other address no write", d, 32'h0040_0024);
        bus_write(ADDR, 32'h0040_0024);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_init_seq();
        t_latch_disabled();
        t_enable();
        t_clear_partial();
        t_level_held();
        t_set_wins();
        t_out_of_range();
        t_addr_miss();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule